// File: doc/BRIEF.md
# Periodic Timer Comparator Channel

This block is a single comparator channel of an event timer. It watches a main counter that runs freely outside the channel and is shared with other channels. When the counter equals the stored comparator value, the channel sets a sticky status flag. When interrupts are enabled, it also drives an interrupt. The channel reads the counter and never writes it.

Software controls the channel through a small register window. The window holds a configuration word, the comparator and a read-only view of the counter. In one-shot mode the comparator stays where software put it. In periodic mode a hidden period value is added to the comparator on every match.

A self-clearing value-set request turns two writes to the comparator address into two separate loads. The first write sets the next trigger time. The second write sets the period. This lets software choose the first deadline independently of the repeat interval.

Top module: `ptc_channel`

## Requirements
- R1: After reset the configuration word reads 0, the comparator reads all ones, the hidden period is 0 and `irq` is low.
- R2: Register map: address 0 is the configuration word, address 1 is the comparator and address 2 is the main counter. The configuration word has these bits: bit0 interrupt enable, bit1 periodic, bit2 narrow (32-bit) mode, bit3 value-set request (always reads 0) and bit4 match status. Address 2 returns the counter input, and writes to it are ignored.
- R3: On a clock edge where the masked comparator equals the masked counter, the status bit becomes 1 after that edge. `irq` equals status AND enable.
- R4: Once status is set it stays set. Writing the configuration word with bit4 = 1 clears it. Writing with bit4 = 0 leaves it unchanged.
- R5: In one-shot mode (bit1 = 0) the comparator keeps its value after a match.
- R6: When no value-set sequence is pending, a comparator write loads both the trigger value and the period.
- R7: A configuration write with bit1 = 1 and bit3 = 1 arms a sequence. The next comparator write loads only the trigger value. The write after that loads only the period and leaves the comparator unchanged. The channel then returns to normal writes.
- R8: A value-set request is ignored when the configuration write selects one-shot mode. A configuration write that leaves periodic mode cancels any pending sequence.
- R9: In periodic mode, each match replaces the comparator with comparator + period.
- R10: In narrow mode only the low 32 bits are compared. Comparator and period writes are stored with the upper bits cleared. The periodic sum wraps at 32 bits.
- R11: If a comparator write and a periodic match fall on the same edge, the written value wins over the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_wdata | input | CNT_W (64) | Write data |
| bus_rdata | output | CNT_W (64) | Read data for `bus_addr` (combinational) |
| main_cnt | input | CNT_W (64) | Shared free-running main counter |
| irq | output | 1 | Interrupt: status AND enable |

## Verification
A register write takes effect at the rising edge during which `bus_wr` is high. Read data is combinational, so it shows the new value one falling edge later. A match is detected at the first rising edge where the counter input equals the comparator. The status bit, `irq` and the periodic reload all appear together after that single edge. The bench therefore drives inputs at a falling edge and reads at the next falling edge. Before each setup it parks the counter on a value that matches nothing, so a write sequence cannot raise a stray match.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_TRIG = 2'd1,
      SEQ_PER  = 2'd2
   } seq_e;

   typedef struct packed {
      logic narrow;
      logic periodic;
      logic en;
   } cfg_t;

   localparam int BIT_EN     = 0;
   localparam int BIT_PER    = 1;
   localparam int BIT_NARROW = 2;
   localparam int BIT_VSET   = 3;
   localparam int BIT_STAT   = 4;

   localparam int ADR_CFG = 0;
   localparam int ADR_CMP = 1;
   localparam int ADR_CNT = 2;
endpackage

// File: rtl/ptc_write_seq.sv
module ptc_write_seq
   import ptc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic cfg_per_nxt,
   input  logic cfg_vset,
   input  logic periodic,
   input  logic cmp_wr,
   output logic ld_trig,
   output logic ld_per
);
   seq_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
      end else if (cfg_wr) begin
         if (!cfg_per_nxt)
            state <= SEQ_IDLE;
         else if (cfg_vset)
            state <= SEQ_TRIG;
      end else if (!periodic) begin
         state <= SEQ_IDLE;
      end else if (cmp_wr) begin
         case (state)
            SEQ_TRIG: state <= SEQ_PER;
            default:  state <= SEQ_IDLE;
         endcase
      end
   end

   assign ld_trig = cmp_wr && (state != SEQ_PER);
   assign ld_per  = cmp_wr && (state != SEQ_TRIG);

   // R8
   seq_needs_periodic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SEQ_IDLE) |-> periodic);

   // R7
   seq_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_PER && cmp_wr && !cfg_wr) |=> (state == SEQ_IDLE));
endmodule

// File: rtl/ptc_match.sv
module ptc_match #(
   parameter int CNT_W      = 64,
   parameter int NARROW_W   = 32,
   parameter bit HAS_NARROW = 1'b1
) (
   input  logic             narrow,
   input  logic [CNT_W-1:0] cmp,
   input  logic [CNT_W-1:0] per,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] mask,
   output logic [CNT_W-1:0] cmp_next,
   output logic             hit
);
   generate
      if (HAS_NARROW) begin : g_narrow
         if (NARROW_W >= CNT_W || NARROW_W < 1) begin : g_bad
            $error("ptc_match: NARROW_W must lie in 1..CNT_W-1");
         end
         localparam int HI_W = CNT_W - NARROW_W;
         assign mask = narrow ? {{HI_W{1'b0}}, {NARROW_W{1'b1}}} : {CNT_W{1'b1}};
      end else begin : g_wide
         assign mask = {CNT_W{1'b1}};
      end
   endgenerate

   assign hit      = ((cmp ^ cnt) & mask) == '0;
   assign cmp_next = (cmp + per) & mask;
endmodule

// File: rtl/ptc_channel.sv
module ptc_channel
   import ptc_pkg::*;
#(
   parameter int CNT_W      = 64,
   parameter int NARROW_W   = 32,
   parameter bit HAS_NARROW = 1'b1,
   parameter int ADDR_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  main_cnt,
   output logic              irq
);
   localparam int CFG_RD_W = BIT_STAT + 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ptc_channel: ADDR_W must be at least 2");
      end
      if (CNT_W <= CFG_RD_W) begin : g_bad_cnt
         $error("ptc_channel: CNT_W too small for the configuration word");
      end
   endgenerate

   cfg_t             cfg;
   logic             stat;
   logic [CNT_W-1:0] cmp;
   logic [CNT_W-1:0] per;
   logic [CNT_W-1:0] mask;
   logic [CNT_W-1:0] cmp_next;
   logic             hit;
   logic             ld_trig;
   logic             ld_per;

   logic cfg_wr;
   logic cmp_wr;
   assign cfg_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CFG));
   assign cmp_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CMP));

   ptc_write_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_per_nxt (bus_wdata[BIT_PER]),
      .cfg_vset    (bus_wdata[BIT_VSET]),
      .periodic    (cfg.periodic),
      .cmp_wr      (cmp_wr),
      .ld_trig     (ld_trig),
      .ld_per      (ld_per)
   );

   ptc_match #(
      .CNT_W      (CNT_W),
      .NARROW_W   (NARROW_W),
      .HAS_NARROW (HAS_NARROW)
   ) u_match (
      .narrow   (cfg.narrow),
      .cmp      (cmp),
      .per      (per),
      .cnt      (main_cnt),
      .mask     (mask),
      .cmp_next (cmp_next),
      .hit      (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (cfg_wr) begin
         cfg.en       <= bus_wdata[BIT_EN];
         cfg.periodic <= bus_wdata[BIT_PER];
         cfg.narrow   <= HAS_NARROW ? bus_wdata[BIT_NARROW] : 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cmp <= '1;
      else if (ld_trig)
         cmp <= bus_wdata & mask;
      else if (cfg.periodic && hit)
         cmp <= cmp_next;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         per <= '0;
      else if (ld_per)
         per <= bus_wdata & mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         stat <= 1'b0;
      else if (hit)
         stat <= 1'b1;
      else if (cfg_wr && bus_wdata[BIT_STAT])
         stat <= 1'b0;
   end

   assign irq = stat && cfg.en;

   always_comb begin
      case (bus_addr)
         ADDR_W'(ADR_CFG): bus_rdata = {{(CNT_W-CFG_RD_W){1'b0}}, stat, 1'b0, cfg};
         ADDR_W'(ADR_CMP): bus_rdata = cmp;
         ADDR_W'(ADR_CNT): bus_rdata = main_cnt;
         default:          bus_rdata = '0;
      endcase
   end

   // R5
   oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.periodic && !ld_trig) |=> $stable(cmp));

   // R9
   reload_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.periodic && hit && !ld_trig) |=>
         (cmp == (($past(cmp) + $past(per)) & $past(mask))));

   // R7
   period_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_per && !ld_trig && !hit) |=> $stable(cmp));

   // R4
   stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && !(cfg_wr && bus_wdata[BIT_STAT])) |=> stat);

   // R3
   match_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cfg.en && !cfg_wr) |=> irq);
endmodule

// File: tb/ptc_channel_bench.sv
module ptc_channel_bench;
   localparam logic [63:0] PARK = 64'h0000_7777_0000_1111;
   localparam logic [63:0] LO32 = 64'h0000_0000_FFFF_FFFF;
   localparam logic [63:0] C_EN = 64'h01, C_PER = 64'h02, C_NAR = 64'h04,
                           C_VS = 64'h08, C_CLR = 64'h10;

   typedef struct packed {
      logic        narrow;
      logic [63:0] cmp;
      logic [63:0] cnt;
      logic        hit;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 64'h10,                  64'h10,                  1'b1},
      '{1'b0, 64'h1_0000_0010,         64'h10,                  1'b0},
      '{1'b1, 64'h1_0000_0010,         64'h10,                  1'b1},
      '{1'b0, 64'h5,                   64'h6,                   1'b0},
      '{1'b1, 64'hABCD_0000_0000_0005, 64'h1234_0000_0000_0005, 1'b1},
      '{1'b1, 64'h0000_0000_FFFF_FFFF, 64'h2_FFFF_FFFF,         1'b1},
      '{1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic [63:0] main_cnt = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ptc_channel u_ptc_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .main_cnt  (main_cnt),
      .irq       (irq)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [63:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic setcnt(input logic [63:0] v);
      @(negedge clk);
      main_cnt = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, r); check("R1 cfg", r, 64'h0);
      rd(2'd1, r); check("R1 cmp", r, '1);
      check("R1 irq", {63'd0, irq}, 64'd0);

      // R2 counter view is read-only
      setcnt(PARK);
      rd(2'd2, r); check("R2 cnt read", r, PARK);
      wr(2'd2, 64'h1234);
      rd(2'd2, r); check("R2 cnt write ignored", r, PARK);
      rd(2'd1, r); check("R2 cmp untouched", r, '1);

      // R3 R10 R5 vector table: one-shot compares
      for (int i = 0; i < NV; i++) begin
         logic [63:0] ecmp;
         setcnt(PARK);
         wr(2'd0, C_EN | C_CLR | (VECS[i].narrow ? C_NAR : 64'h0));
         wr(2'd1, VECS[i].cmp);
         ecmp = VECS[i].narrow ? (VECS[i].cmp & LO32) : VECS[i].cmp;
         rd(2'd1, r); check("R10 cmp store", r, ecmp);
         setcnt(VECS[i].cnt);
         rd(2'd0, r); check("R3 status", {63'd0, r[4]}, {63'd0, VECS[i].hit});
         check("R3 irq", {63'd0, irq}, {63'd0, VECS[i].hit});
         rd(2'd1, r); check("R5 cmp after match", r, ecmp);
      end

      // R7 value-set sequence, R9 periodic reload
      setcnt(PARK);
      wr(2'd0, C_EN | C_PER | C_VS | C_CLR);
      rd(2'd0, r); check("R7 vset reads 0", r, C_EN | C_PER);
      wr(2'd1, 64'd200);
      rd(2'd1, r); check("R7 trigger load", r, 64'd200);
      wr(2'd1, 64'd50);
      rd(2'd1, r); check("R7 period write keeps cmp", r, 64'd200);
      setcnt(64'd200);
      rd(2'd1, r); check("R9 reload", r, 64'd250);
      check("R3 periodic irq", {63'd0, irq}, 64'd1);
      setcnt(PARK);
      wr(2'd0, C_EN | C_PER | C_CLR);
      rd(2'd0, r); check("R4 w1c clears", {63'd0, r[4]}, 64'd0);
      setcnt(64'd250);
      rd(2'd1, r); check("R9 second reload", r, 64'd300);

      // R3 enable gating, R4 write of 0 keeps status
      setcnt(PARK);
      wr(2'd0, C_PER | C_CLR);
      setcnt(64'd300);
      rd(2'd0, r); check("R3 status no enable", {63'd0, r[4]}, 64'd1);
      check("R3 irq gated", {63'd0, irq}, 64'd0);
      setcnt(PARK);
      wr(2'd0, C_EN | C_PER);
      rd(2'd0, r); check("R4 zero keeps status", {63'd0, r[4]}, 64'd1);
      check("R3 irq after enable", {63'd0, irq}, 64'd1);

      // R11 write beats reload (cmp now 350)
      wr(2'd0, C_PER | C_CLR);
      @(negedge clk);
      main_cnt = 64'd350;
      bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 64'd999;
      @(negedge clk);
      bus_wr = 1'b0;
      main_cnt = PARK;
      rd(2'd1, r); check("R11 write wins", r, 64'd999);

      // R8 value-set ignored in one-shot; R6 plain write loads period
      setcnt(PARK);
      wr(2'd0, C_VS);
      wr(2'd1, 64'd500);
      wr(2'd1, 64'd7);
      rd(2'd1, r); check("R8 one-shot vset ignored", r, 64'd7);
      wr(2'd0, C_PER);
      setcnt(64'd7);
      rd(2'd1, r); check("R6 period from plain write", r, 64'd14);

      // R8 leaving periodic cancels sequence
      setcnt(PARK);
      wr(2'd0, C_PER | C_VS);
      wr(2'd1, 64'd1000);
      wr(2'd0, 64'h0);
      wr(2'd1, 64'd30);
      rd(2'd1, r); check("R8 cancel cmp", r, 64'd30);
      wr(2'd0, C_PER);
      setcnt(64'd30);
      rd(2'd1, r); check("R8 cancel period", r, 64'd60);

      // R10 narrow periodic wrap
      setcnt(PARK);
      wr(2'd0, C_PER | C_NAR | C_CLR);
      wr(2'd1, 64'h0000_0000_FFFF_FFF0);
      setcnt(64'h1_FFFF_FFF0);
      rd(2'd1, r); check("R10 narrow wrap", r, 64'h0000_0000_FFFF_FFE0);
      rd(2'd0, r); check("R10 narrow status", {63'd0, r[4]}, 64'd1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule